// File: doc/BRIEF.md
# Pseudo-DMA Handshake Timeout Watchdog

This block watches a blind, host-driven pseudo-DMA data path to a SCSI bus controller and catches two faults: a ready handshake that never finishes, and a byte left stuck in a holding register. The host sets a reload value and an interrupt mask in an 8-bit control register. Each time a handshake completes, a 7-bit down-counter reloads from that value. While a transfer is waiting, the counter steps down once per prescaled tick. The tick is the input clock divided by 14, so a 28.224 MHz input gives about 2.016 MHz. When the counter reaches zero, the block latches a timeout flag and can raise an interrupt.

A second source of interrupt watches the controller's data request line. Software arms it through a bit in the status register. The next rising edge of the request, taken after a two-flop synchronizer, latches the interrupt. No status bit reports this interrupt; only the arm bit reads back. The single `irq` output is the OR of the unmasked timeout interrupt and the latched request interrupt. Both registers read back continuously on their own output buses.

Top module: `pdma_watchdog`

## Requirements
- R1: After reset, the control readback is 0x80 (timeout interrupt masked, reload 0), the status readback is 0x00 and `irq` is low. The prescaler, the counter, the flag, the arm bit and the request interrupt are all cleared.
- R2: A `wr_ctl` strobe stores all 8 bits of `wdata`, and `ctl_rd` returns them from the next cycle. Bits 6..0 are the reload value and bit 7 is the interrupt mask.
- R3: The prescaler runs freely and fires one tick every DIV clocks (DIV=14), starting DIV clocks after reset. The counter decrements only on a tick while `xfer_wait` is high and the count is not zero.
- R4: A `hs_done` pulse reloads the counter from control bits 6..0 and takes priority over a decrement in the same cycle. With a reload value of 0 the counter stays at zero and never expires.
- R5: A decrement from 1 to 0 sets the timeout flag. The flag reads as status bit 7 and stays set until the host clears it.
- R6: The timeout contributes to `irq` only while control bit 7 is 0. The mask leaves the flag itself unchanged.
- R7: Any `wr_stat` strobe clears the timeout flag, whatever value is written. If an expiry happens in the same cycle, the expiry wins and the flag stays set.
- R8: A `wr_stat` strobe loads the arm bit from `wdata` bit 3, and the arm bit reads back as status bit 3. While the arm bit is set, a rising edge of `dreq_async` latches the request interrupt, and `irq` goes high three clocks after the edge is first sampled. No status bit reflects the request interrupt.
- R9: A `wr_stat` strobe with bit 3 at 0 clears both the arm bit and the request interrupt. Request edges seen while the arm bit is clear have no effect.
- R10: Status bits 6..4 and 2..0 always read as zero.
- R11: While `xfer_wait` is low the count holds, and the counter resumes from the same value when waiting resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, nominally 28.224 MHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_ctl | input | 1 | Single-cycle write strobe for the control register |
| wr_stat | input | 1 | Single-cycle write strobe for the status register |
| wdata | input | 8 | Write data shared by both strobes |
| xfer_wait | input | 1 | High while a transfer waits on the ready handshake |
| hs_done | input | 1 | One-cycle pulse when a handshake completes |
| dreq_async | input | 1 | Data request from the controller, asynchronous |
| ctl_rd | output | 8 | Control register readback |
| stat_rd | output | 8 | Status readback: bit 7 is the timeout flag, bit 3 is the arm bit |
| irq | output | 1 | Combined interrupt output |

## Verification
The counter is tested with four waiting patterns: an unbroken wait, a wait broken into pieces by idle gaps, a wait cut short by a handshake reload, and a wait with a reload value of zero. Together these separate tick counting from a hold, a reload and a disabled counter. The timeout interrupt is tried both masked and unmasked, and it is cleared by writes of several data values, including one written in the cycle of expiry. Request edges arrive while disarmed, while armed and in the cycle the arm bit is written. This shows the synchronizer delay and that a new edge is needed before the interrupt is latched.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

  localparam int REG_W       = 8;
  localparam int CNT_W       = 7;
  localparam int CTL_MASK_B  = 7;
  localparam int STAT_TO_B   = 7;
  localparam int STAT_ARM_B  = 3;

  typedef struct packed {
    logic [CNT_W-1:0] nxt;
    logic             expire;
  } cnt_step_t;

  // One step of the handshake down-counter.
  function automatic cnt_step_t count_step(
    input logic [CNT_W-1:0] cur,
    input logic             load,
    input logic [CNT_W-1:0] reload,
    input logic             step
  );
    cnt_step_t r;
    r.nxt    = cur;
    r.expire = 1'b0;
    if (load) begin
      r.nxt = reload;
    end else if (step && (cur != '0)) begin
      r.nxt    = cur - 1'b1;
      r.expire = (cur == CNT_W'(1));
    end
    return r;
  endfunction

  // Status image seen by the host.
  function automatic logic [REG_W-1:0] stat_image(
    input logic flag,
    input logic arm
  );
    logic [REG_W-1:0] v;
    v             = '0;
    v[STAT_TO_B]  = flag;
    v[STAT_ARM_B] = arm;
    return v;
  endfunction

  // Next value of a modulo prescale counter.
  function automatic int unsigned pre_next(
    input int unsigned cur,
    input int unsigned div
  );
    return (cur == div - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/pdw_prescaler.sv
module pdw_prescaler #(
  parameter int DIV = 14
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pc_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pc_q <= '0;
        end else begin
          pc_q <= PW'(pdw_pkg::pre_next(32'(pc_q), DIV));
        end
      end

      assign tick_o = (pc_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pdw_countdown.sv
module pdw_countdown
  import pdw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wait_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  cnt_step_t        st;
  logic             step_w;

  assign step_w = tick_i & wait_i;

  always_comb begin
    st = count_step(cnt_q, load_i, reload_i, step_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= st.nxt;
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = st.expire;
endmodule

// File: rtl/pdw_reqedge.sv
module pdw_reqedge #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  input  logic arm_i,
  input  logic clr_i,
  output logic edge_o,
  output logic rq_o
);
  logic synced_w;
  logic prev_q;
  logic rq_q;

  generate
    if (SYNC_N < 2) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= req_async;
      end
      assign synced_w = s_q;
    end else begin : g_syncn
      logic [SYNC_N-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC_N-2:0], req_async};
      end
      assign synced_w = sh_q[SYNC_N-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced_w;
  end

  assign edge_o = synced_w & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_q <= 1'b0;
    end else if (clr_i) begin
      rq_q <= 1'b0;
    end else if (arm_i && edge_o) begin
      rq_q <= 1'b1;
    end
  end

  assign rq_o = rq_q;
endmodule

// File: rtl/pdma_watchdog.sv
module pdma_watchdog
  import pdw_pkg::*;
#(
  parameter int DIV    = 14,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic             wr_stat,
  input  logic [REG_W-1:0] wdata,
  input  logic             xfer_wait,
  input  logic             hs_done,
  input  logic             dreq_async,
  output logic [REG_W-1:0] ctl_rd,
  output logic [REG_W-1:0] stat_rd,
  output logic             irq
);
  localparam logic [REG_W-1:0] CTL_RST = REG_W'(1) << CTL_MASK_B;

  logic [REG_W-1:0] ctl_q;
  logic             flag_q;
  logic             arm_q;
  logic             tick_w;
  logic [CNT_W-1:0] cnt_w;
  logic             expire_w;
  logic             edge_w;
  logic             rq_w;
  logic             disarm_w;
  logic             to_irq_w;

  pdw_prescaler #(.DIV(DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_w)
  );

  pdw_countdown u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_w),
    .wait_i   (xfer_wait),
    .load_i   (hs_done),
    .reload_i (ctl_q[CNT_W-1:0]),
    .cnt_o    (cnt_w),
    .expire_o (expire_w)
  );

  assign disarm_w = wr_stat & ~wdata[STAT_ARM_B];

  pdw_reqedge #(.SYNC_N(SYNC_N)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_async (dreq_async),
    .arm_i     (arm_q),
    .clr_i     (disarm_w),
    .edge_o    (edge_w),
    .rq_o      (rq_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
    end else if (wr_ctl) begin
      ctl_q <= wdata;
    end
  end

  // Expiry wins over a clearing write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (expire_w) begin
      flag_q <= 1'b1;
    end else if (wr_stat) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
    end else if (wr_stat) begin
      arm_q <= wdata[STAT_ARM_B];
    end
  end

  assign to_irq_w = flag_q & ~ctl_q[CTL_MASK_B];
  assign irq      = to_irq_w | rq_w;
  assign ctl_rd   = ctl_q;
  assign stat_rd  = stat_image(flag_q, arm_q);
endmodule

// File: rtl/pdw_checker.sv
module pdw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stat,
  input logic [7:0] wdata,
  input logic       xfer_wait,
  input logic       hs_done,
  input logic [7:0] ctl,
  input logic [7:0] stat,
  input logic       irq,
  input logic [6:0] cnt,
  input logic       tick,
  input logic       expire,
  input logic       arm,
  input logic       rq
);
  p_decr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && xfer_wait && !hs_done && cnt != 7'd0) |=> cnt == ($past(cnt) - 7'd1));

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hs_done |=> cnt == $past(ctl[6:0]));

  p_expire_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> stat[7]);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[7] && !wr_stat) |=> stat[7]);

  p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[7] && !rq) |-> !irq);

  p_wr_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !expire) |=> !stat[7]);

  p_edge_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rq) |-> $past(arm));

  p_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !wdata[3]) |=> (!rq && !stat[3]));

  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[6:4] == 3'b000) && (stat[2:0] == 3'b000));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_wait && !hs_done) |=> $stable(cnt));
endmodule

bind pdma_watchdog pdw_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_stat   (wr_stat),
  .wdata     (wdata),
  .xfer_wait (xfer_wait),
  .hs_done   (hs_done),
  .ctl       (ctl_rd),
  .stat      (stat_rd),
  .irq       (irq),
  .cnt       (cnt_w),
  .tick      (tick_w),
  .expire    (expire_w),
  .arm       (arm_q),
  .rq        (rq_w)
);

// File: tb/sim_pdma_watchdog.sv
module sim_pdma_watchdog;
  localparam int CLK_PER = 10;
  localparam int DIV     = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_ctl = 1'b0;
  logic       wr_stat = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       xfer_wait = 1'b0;
  logic       hs_done = 1'b0;
  logic       dreq_async = 1'b0;
  logic [7:0] ctl_rd;
  logic [7:0] stat_rd;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string req_tag = "R1";

  pdma_watchdog #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_stat(wr_stat),
    .wdata(wdata), .xfer_wait(xfer_wait), .hs_done(hs_done),
    .dreq_async(dreq_async), .ctl_rd(ctl_rd), .stat_rd(stat_rd), .irq(irq)
  );

  always #(CLK_PER/2) clk = ~clk;

  // Behavioural reference state
  int m_pre, m_cnt, m_ctl;
  bit m_flag, m_arm, m_rq, m_s1, m_s2, m_prv;

  always @(posedge clk) begin
    bit tk, exp_now, edg;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_ctl = 128;
      m_flag = 0; m_arm = 0; m_rq = 0; m_s1 = 0; m_s2 = 0; m_prv = 0;
    end else begin
      tk = (m_pre == DIV - 1);
      m_pre = (m_pre + 1) % DIV;
      exp_now = 0;
      if (hs_done) m_cnt = m_ctl % 128;
      else if (tk && xfer_wait && m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) exp_now = 1;
      end
      if (exp_now) m_flag = 1;
      else if (wr_stat) m_flag = 0;
      edg = m_s2 && !m_prv;
      if (wr_stat && !wdata[3]) m_rq = 0;
      else if (m_arm && edg) m_rq = 1;
      if (wr_stat) m_arm = wdata[3];
      if (wr_ctl) m_ctl = wdata;
      m_prv = m_s2; m_s2 = m_s1; m_s1 = dreq_async;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_PER/4);
    if (rst_n && !done) begin
      check(req_tag, "ctl_rd", ctl_rd, m_ctl);
      check(req_tag, "stat_rd", stat_rd, {m_flag, 3'b000, m_arm, 3'b000});
      check(req_tag, "irq", irq, (m_flag && !m_ctl[7]) || m_rq);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wctl(input logic [7:0] v);
    @(negedge clk); wr_ctl = 1; wdata = v;
    @(negedge clk); wr_ctl = 0;
  endtask

  task automatic wstat(input logic [7:0] v);
    @(negedge clk); wr_stat = 1; wdata = v;
    @(negedge clk); wr_stat = 0;
  endtask

  task automatic hs();
    @(negedge clk); hs_done = 1;
    @(negedge clk); hs_done = 0;
  endtask

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R1: reset values held while in reset
    check("R1", "ctl reset", ctl_rd, 8'h80);
    check("R1", "stat reset", stat_rd, 8'h00);
    check("R1", "irq reset", irq, 0);
    rst_n = 1;
    cyc(5);

    req_tag = "R2";
    wctl(8'h05);
    cyc(1);
    check("R2", "ctl readback", ctl_rd, 8'h05);

    // R3 R5: unbroken wait, masked irq (R6)
    req_tag = "R3";
    wctl(8'h85);
    hs();
    @(negedge clk); xfer_wait = 1;
    cyc(5 * DIV + 4);
    req_tag = "R5";
    check("R5", "flag after expiry", stat_rd[7], 1);
    check("R6", "masked irq", irq, 0);
    cyc(20);
    check("R5", "flag sticky", stat_rd[7], 1);
    req_tag = "R6";
    wctl(8'h05);
    cyc(1);
    check("R6", "unmasked irq", irq, 1);

    // R7: clear by any value
    req_tag = "R7";
    wstat(8'h77);
    cyc(1);
    check("R7", "flag cleared", stat_rd[7], 0);
    check("R7", "irq cleared", irq, 0);
    hs();
    cyc(5 * DIV + 4);
    wstat(8'h80);
    cyc(1);
    check("R7", "cleared by 0x80", stat_rd[7], 0);

    // R7: write during expiry cycle; sweep write timing around it
    for (int k = 0; k < 2 * DIV; k++) begin
      hs();
      cyc(k + 3 * DIV);
      wstat(8'h00);
      cyc(3 * DIV);
      wstat(8'h00);
    end

    // R11: broken wait
    req_tag = "R11";
    wctl(8'h06);
    hs();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); xfer_wait = 1;
      cyc(DIV / 2);
      @(negedge clk); xfer_wait = 0;
      cyc(DIV + 3);
    end
    xfer_wait = 1;
    cyc(8 * DIV);
    check("R11", "eventual expiry", stat_rd[7], 1);
    wstat(8'h00);

    // R4: reload cuts wait short; reload priority
    req_tag = "R4";
    wctl(8'h03);
    for (int i = 0; i < 6; i++) begin
      hs();
      cyc(2 * DIV);
    end
    check("R4", "no expiry while reloading", stat_rd[7], 0);
    @(negedge clk); hs_done = 1;
    cyc(3 * DIV);
    check("R4", "held reload no expiry", stat_rd[7], 0);
    hs_done = 0;
    wctl(8'h00);
    hs();
    cyc(300 * DIV / 14 + 200);
    check("R4", "reload zero never expires", stat_rd[7], 0);
    wctl(8'h7F);
    hs();
    cyc(127 * DIV + 20);
    check("R3", "long count expired", stat_rd[7], 1);
    xfer_wait = 0;
    wstat(8'h00);

    // R9: edges while disarmed ignored
    req_tag = "R9";
    @(negedge clk); dreq_async = 1;
    cyc(6);
    check("R9", "unarmed edge ignored", irq, 0);
    @(negedge clk); dreq_async = 0;
    cyc(4);

    // R8: arm then edge
    req_tag = "R8";
    wstat(8'h08);
    cyc(2);
    check("R8", "arm reads back", stat_rd, 8'h08);
    @(negedge clk); dreq_async = 1;
    cyc(2);
    check("R8", "not yet latched", irq, 0);
    cyc(1);
    check("R8", "latched", irq, 1);
    check("R10", "no rq status bit", stat_rd, 8'h08);
    @(negedge clk); dreq_async = 0;
    cyc(4);
    check("R8", "rq sticky", irq, 1);
    wstat(8'h08);
    cyc(1);
    check("R8", "rewrite arm keeps rq", irq, 1);

    req_tag = "R9";
    wstat(8'hF7);
    cyc(1);
    check("R9", "disarm clears", irq, 0);
    check("R10", "unused bits zero", stat_rd, 8'h00);

    // Edge near the arming write: sweep relative timing
    req_tag = "R8";
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); dreq_async = 1;
      cyc(k);
      wstat(8'h08);
      cyc(6);
      @(negedge clk); dreq_async = 0;
      cyc(4);
      wstat(8'h00);
    end

    req_tag = "R10";
    cyc(10);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule